// File: doc/BRIEF.md
# Sound Command Latch with Interrupt Fan-out

This block takes command bytes from a main processor and hands them to one or two sound processors. Every incoming byte is cut down to its low six bits. If the low four bits of that result are all ones, the byte is treated as "no command" and dropped. Any other value is kept in a latch, and an interrupt request goes to the sound side.

The sound processors read the command through a small register window that behaves like a peripheral I/O chip. Offset 0 gives back the complement of the latched command. Offset 2 gives a constant that means the test switch is released. Offset 5 gives a constant that reports an edge on bit 7 of the command port. Every other offset is a plain scratch register that can be read and written.

A mode input chooses how many sound processors are interrupted: only the first, or all of them together. Each interrupt line stays high until its own processor acknowledges it, either with a pulse on its acknowledge input or by reading the command port.

Top module: `snd_cmd_latch`

## Requirements
- R1: A command byte is reduced to its low 6 bits before it is used. The latch therefore always holds bits 7:6 as zero, so a port A read of a stored command returns 1 in bits 7:6.
- R2: A write whose masked value has bits 3:0 equal to 4'hF leaves the latch unchanged and raises no interrupt.
- R3: A write with any other value stores the masked byte. In the next cycle the interrupt of every enabled target is high.
- R4: When `multi_mode` is 0, only `irq[0]` is ever set. When it is 1, `irq[0]` and `irq[1]` are set in the same cycle.
- R5: A read at offset 0 returns the bitwise complement of the latch value held in the read cycle. The result appears on `rdata` one cycle later, and `rdata` keeps it until the next read.
- R6: A read at offset 2 returns 8'h40.
- R7: A read at offset 5 returns 8'h40.
- R8: Only address bits 4:0 select a register, so higher address bits are ignored. A read at any offset other than 0, 2 or 5 returns the last value written to that offset.
- R9: Each `irq[k]` stays high until `irq_ack[k]` is 1, or until a read at offset 0 with `rd_id` equal to k. A new trigger in the same cycle as the clear wins, and the line stays high.
- R10: While `rst` is high and after it is released, the latch is 8'h00, every scratch register is 0, `rdata` is 0 and every `irq` output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Main-side command write strobe |
| cmd_data | input | 8 | Main-side command byte |
| multi_mode | input | 1 | 0: interrupt the first sound CPU only; 1: interrupt all of them |
| irq_ack | input | 2 | Per-target acknowledge pulse |
| rd_en | input | 1 | Sound-side read strobe |
| wr_en | input | 1 | Sound-side write strobe |
| rd_id | input | 1 | Index of the sound CPU doing the read |
| addr | input | 7 | Sound-side register address (bits 4:0 decoded) |
| wdata | input | 8 | Sound-side write data |
| rdata | output | 8 | Registered read data |
| irq | output | 2 | Interrupt requests toward the sound CPUs |

## Verification
Commands are sent in both interrupt modes. The command values are chosen so that non-zero upper bits show the masking, and 4'hF low nibbles with different upper bits (0x2F, 0x3F, 0xFF) show that the filter looks only at the nibble. Some acknowledges arrive in the same cycle as a new trigger, which exposes the order in which set and clear take effect. A command-port read from the second processor clears only that processor's line. Scratch registers are written and read back through aliased addresses, while the two constant offsets and offset 0 are read through both aliased and direct addresses. This separates real decode of the five address bits from a full-width compare.

// File: rtl/snd_cmd_pkg.sv
package snd_cmd_pkg;
  localparam int unsigned OFS_PORT_A = 0;
  localparam int unsigned OFS_PORT_B = 2;
  localparam int unsigned OFS_IFLAG  = 5;
  localparam logic [7:0]  PORT_B_VAL = 8'h40;
  localparam logic [7:0]  IFLAG_VAL  = 8'h40;
endpackage

// File: rtl/snd_cmd_filter.sv
module snd_cmd_filter #(
  parameter int DATA_W = 8,
  parameter int CMD_W  = 6,
  parameter int TRIG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] latch_q,
  output logic              trig
);
  localparam int PAD_W = DATA_W - CMD_W;

  logic [DATA_W-1:0] masked;
  logic [PAD_W-1:0]  unused_cmd_hi;

  assign unused_cmd_hi = cmd_data[DATA_W-1:CMD_W];
  assign masked = {{PAD_W{1'b0}}, cmd_data[CMD_W-1:0]};
  assign trig   = cmd_we && (masked[TRIG_W-1:0] != {TRIG_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else if (trig) latch_q <= masked;
  end

  // R2: an all-ones nibble leaves the latch untouched
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_data[TRIG_W-1:0] == {TRIG_W{1'b1}}) |=> $stable(latch_q));

  // R1: stored command carries the written low bits
  a_r1_latch_low: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_data[TRIG_W-1:0] != {TRIG_W{1'b1}})
      |=> latch_q[CMD_W-1:0] == $past(cmd_data[CMD_W-1:0]));
endmodule

// File: rtl/snd_irq_ctrl.sv
module snd_irq_ctrl #(
  parameter int N_IRQ = 2,
  parameter int ID_W  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic             multi_mode,
  input  logic [N_IRQ-1:0] irq_ack,
  input  logic             port_a_rd,
  input  logic [ID_W-1:0]  rd_id,
  output logic [N_IRQ-1:0] irq
);
  logic [N_IRQ-1:0] irq_q;
  logic [N_IRQ-1:0] en;
  logic [N_IRQ-1:0] clr;

  for (genvar k = 0; k < N_IRQ; k++) begin : g_tgt
    if (k == 0) begin : g_first
      assign en[k] = 1'b1;
    end else begin : g_rest
      assign en[k] = multi_mode;
    end

    assign clr[k] = irq_ack[k] || (port_a_rd && (rd_id == ID_W'(k)));

    always_ff @(posedge clk) begin
      if (rst) irq_q[k] <= 1'b0;
      else if (trig && en[k]) irq_q[k] <= 1'b1;
      else if (clr[k]) irq_q[k] <= 1'b0;
    end

    // R3: a trigger raises each enabled line
    a_r3_irq_raise: assert property (@(posedge clk) disable iff (rst)
      (trig && en[k]) |=> irq_q[k]);

    // R9: a raised line holds until cleared
    a_r9_irq_hold: assert property (@(posedge clk) disable iff (rst)
      (irq_q[k] && !irq_ack[k] && !(port_a_rd && rd_id == ID_W'(k))) |=> irq_q[k]);

    // R9: a clear without a trigger drops the line
    a_r9_irq_clear: assert property (@(posedge clk) disable iff (rst)
      (irq_ack[k] && !trig) |=> !irq_q[k]);

    if (k > 0) begin : g_chk_multi
      // R4: disabled targets stay quiet
      a_r4_single_quiet: assert property (@(posedge clk) disable iff (rst)
        (!multi_mode && !irq_q[k]) |=> !irq_q[k]);
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/snd_reg_window.sv
module snd_reg_window
  import snd_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] latch_q,
  output logic [DATA_W-1:0] rdata,
  output logic              port_a_rd
);
  localparam int DEPTH = 1 << REG_AW;

  logic [DATA_W-1:0] regs [DEPTH];
  logic [DATA_W-1:0] rd_mux;

  assign port_a_rd = rd_en && (addr == REG_AW'(OFS_PORT_A));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[addr] <= wdata;
    end
  end

  always_comb begin
    if (addr == REG_AW'(OFS_PORT_A))      rd_mux = ~latch_q;
    else if (addr == REG_AW'(OFS_PORT_B)) rd_mux = DATA_W'(PORT_B_VAL);
    else if (addr == REG_AW'(OFS_IFLAG))  rd_mux = DATA_W'(IFLAG_VAL);
    else                                  rd_mux = regs[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R5: port A returns the complement of the latch
  a_r5_port_a_inv: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_AW'(OFS_PORT_A)) |=> rdata == ~$past(latch_q));

  // R6: port B constant
  a_r6_port_b: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_AW'(OFS_PORT_B)) |=> rdata == DATA_W'(PORT_B_VAL));

  // R7: interrupt flag constant
  a_r7_iflag: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_AW'(OFS_IFLAG)) |=> rdata == DATA_W'(IFLAG_VAL));

  // R5: read data holds between reads
  a_r5_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/snd_cmd_latch.sv
module snd_cmd_latch #(
  parameter int DATA_W = 8,
  parameter int CMD_W  = 6,
  parameter int TRIG_W = 4,
  parameter int ADDR_W = 7,
  parameter int REG_AW = 5,
  parameter int N_IRQ  = 2,
  localparam int ID_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              multi_mode,
  input  logic [N_IRQ-1:0]  irq_ack,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   rd_id,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_IRQ-1:0]  irq
);
  logic [DATA_W-1:0]        latch_q;
  logic                     trig;
  logic                     port_a_rd;
  logic [ADDR_W-REG_AW-1:0] unused_addr_hi;

  assign unused_addr_hi = addr[ADDR_W-1:REG_AW];

  snd_cmd_filter #(.DATA_W(DATA_W), .CMD_W(CMD_W), .TRIG_W(TRIG_W)) u_filter (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .latch_q(latch_q), .trig(trig)
  );

  snd_reg_window #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_window (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr[REG_AW-1:0]), .wdata(wdata), .latch_q(latch_q),
    .rdata(rdata), .port_a_rd(port_a_rd)
  );

  snd_irq_ctrl #(.N_IRQ(N_IRQ), .ID_W(ID_W)) u_irq (
    .clk(clk), .rst(rst), .trig(trig), .multi_mode(multi_mode),
    .irq_ack(irq_ack), .port_a_rd(port_a_rd), .rd_id(rd_id), .irq(irq)
  );

  // R10: outputs quiet in the cycle after reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (irq == '0 && rdata == '0));
endmodule

// File: tb/snd_cmd_latch_tb.sv
module snd_cmd_latch_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, cmd_we, multi_mode, rd_en, wr_en, rd_id;
  logic [7:0] cmd_data, wdata, rdata;
  logic [1:0] irq_ack, irq;
  logic [6:0] addr;

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";

  logic [7:0] m_latch, m_rdata;
  logic [1:0] m_irq;
  logic [7:0] m_regs [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  snd_cmd_latch u_dut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .multi_mode(multi_mode), .irq_ack(irq_ack), .rd_en(rd_en), .wr_en(wr_en),
    .rd_id(rd_id), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic model_step();
    logic [7:0] mc;
    logic       valid;
    logic [4:0] a;
    logic [1:0] nirq;
    if (rst) begin
      m_latch = 8'h00; m_rdata = 8'h00; m_irq = 2'b00;
      for (int i = 0; i < 32; i++) m_regs[i] = 8'h00;
      return;
    end
    mc    = cmd_data & 8'h3F;
    valid = cmd_we && (mc[3:0] != 4'hF);
    a     = addr[4:0];
    for (int k = 0; k < 2; k++) begin
      bit set, clr;
      set = valid && (k == 0 || multi_mode);
      clr = irq_ack[k] || (rd_en && a == 5'd0 && int'(rd_id) == k);
      nirq[k] = set ? 1'b1 : (clr ? 1'b0 : m_irq[k]);
    end
    if (rd_en) begin
      if (a == 5'd0)      m_rdata = ~m_latch;
      else if (a == 5'd2) m_rdata = 8'h40;
      else if (a == 5'd5) m_rdata = 8'h40;
      else                m_rdata = m_regs[a];
    end
    if (wr_en) m_regs[a] = wdata;
    if (valid) m_latch = mc;
    m_irq = nirq;
  endtask

  task automatic compare();
    checks++;
    if (irq !== m_irq) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, m_irq);
    end
    checks++;
    if (rdata !== m_rdata) begin
      errors++;
      $display("FAIL %s rdata actual=%h expected=%h", cur_req, rdata, m_rdata);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic quiet();
    cmd_we = 0; rd_en = 0; wr_en = 0; irq_ack = 2'b00;
  endtask

  task automatic send(input logic [7:0] v);
    cmd_we = 1; cmd_data = v; cyc(); quiet();
  endtask

  task automatic rd(input logic [6:0] a, input logic id);
    rd_en = 1; addr = a; rd_id = id; cyc(); quiet();
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d; cyc(); quiet();
  endtask

  task automatic ack(input logic [1:0] m);
    irq_ack = m; cyc(); quiet();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; quiet(); multi_mode = 0; rd_id = 0; addr = '0;
    cmd_data = '0; wdata = '0;
    @(negedge clk);
    cur_req = "R10"; cyc(); cyc();
    rst = 0; cyc();
    rd(7'h00, 0);                     // R10: latch 0 -> port A reads FF

    cur_req = "R3"; send(8'h12); cyc();
    cur_req = "R5"; rd(7'h00, 0); cyc(); // R5 and R9 clear by read
    cur_req = "R1"; send(8'hC5); rd(7'h40, 0);
    cur_req = "R2"; send(8'h2F); send(8'h3F); send(8'hFF); rd(7'h00, 0);
    cur_req = "R4"; send(8'h01); cyc(); // single mode: irq[1] stays low
    ack(2'b01);

    multi_mode = 1;
    cur_req = "R4"; send(8'h2A); cyc();
    cur_req = "R9"; ack(2'b10); cyc(); rd(7'h20, 1); rd(7'h00, 0);
    send(8'h33); rd(7'h00, 1); cyc(); ack(2'b01);
    // R9: trigger and acknowledge together, set wins
    irq_ack = 2'b11; cmd_we = 1; cmd_data = 8'h04; cyc(); quiet(); cyc();
    ack(2'b11);

    cur_req = "R6"; rd(7'h02, 0); rd(7'h62, 1);
    cur_req = "R7"; rd(7'h05, 0); rd(7'h25, 0);
    cur_req = "R8";
    wr(7'h07, 8'hA5); wr(7'h5F, 8'h3C); wr(7'h01, 8'h99);
    rd(7'h47, 0); rd(7'h1F, 0); rd(7'h21, 0); rd(7'h03, 0);
    wr(7'h02, 8'h11); rd(7'h02, 0);   // R6: written value does not show at port B
    wr(7'h00, 8'h55); rd(7'h00, 0);   // R5: port A still the complement

    cur_req = "R10"; send(8'h08); rst = 1; cyc(); rst = 0; cyc(); rd(7'h07, 0);
    rd(7'h00, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule